// File: doc/BRIEF.md
# Auto-Indexing Pointer Register File

This block keeps eight 16-bit registers for a small processor core and turns them into memory addresses for indirect operand accesses. A request names a register and says whether the access is a read or a write. The block places that register's value on the address output. After the access it updates the register by that register's own rule. Some registers advance after every access. The stack register moves up on reads and down on writes. The low four registers never change as a result of an access.

A separate arm input models the instruction that selects byte-wide operand fetch. Once it is armed, the next read request makes two accesses at consecutive pointer positions. It keeps the low byte of each returned word and combines the two bytes into one 16-bit operand. The armed state applies to exactly one request and is cleared when that request completes. Decode, arithmetic and external bus timing are handled outside the block. Memory returns read data one cycle after the address is issued.

A sequencer with four named states drives every access. IDLE goes to FIRST when it accepts a request. FIRST goes to SECOND for a byte-mode read and to DONE otherwise. SECOND always goes to DONE, and DONE always returns to IDLE.

Top module: `ptr_regfile`

## Requirements
- R1: After reset, register 7 reads 0x1000, registers 0 to 6 read 0x0000, `dbl_flag` is 0 and `op_done` is 0.
- R2: A write on the register port (`wr_en`, `wr_sel`, `wr_data`) takes effect at the clock edge, and `rd_data` then shows the new value of the register chosen by `rd_sel`.
- R3: In the first access cycle, `mem_addr` equals the current value of the requested register. `mem_rd` is high for a read and `mem_wr` is high for a write, and the two are never high together.
- R4: Registers 4, 5 and 7 increase by one after each access made through them, whether read or write, and wrap from 0xFFFF to 0x0000.
- R5: Register 6 increases by one after a read access and decreases by one after a write access, and wraps from 0x0000 to 0xFFFF.
- R6: Registers 0 to 3 keep their value through any indirect access. A byte-mode read through one of them fetches the same address twice.
- R7: A read request accepted at clock edge n issues its access in the cycle after edge n. `op_done` is high for the cycle after edge n+1 (byte mode: n+2), and `op_data` then carries the full 16-bit word returned by memory.
- R8: A pulse on `dbl_arm` sets `dbl_flag`. The next read makes two accesses, the second at the already-advanced pointer value. `op_data` is {second word bits 7:0, first word bits 7:0}, and bits 15:8 of both returned words are ignored.
- R9: `dbl_flag` clears in the cycle that follows `op_done`. A write request made while the flag is set uses one access and still clears the flag. The request after that one is a plain single-word read.
- R10: A request is accepted only in IDLE. A `req_valid` pulse while an access is in progress causes no bus access and no register change.
- R11: `op_done` lasts exactly one cycle. After a read completes, `op_data` keeps that operand until the next completion, and a write completion leaves it unchanged.
- R12: If the register port writes a register in the same cycle that the pointer update targets it, the port value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register port write enable |
| wr_sel | input | 3 | Register port write index |
| wr_data | input | 16 | Register port write value |
| rd_sel | input | 3 | Register port read index |
| rd_data | output | 16 | Value of register `rd_sel` |
| dbl_arm | input | 1 | Arms byte-wide operand mode for the next request |
| dbl_flag | output | 1 | Byte-wide mode currently armed |
| req_valid | input | 1 | Indirect access request |
| req_reg | input | 3 | Register used as the pointer |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read word, valid the cycle after `mem_rd` |
| op_done | output | 1 | One-cycle completion strobe |
| op_data | output | 16 | Assembled operand |

## Verification
The hardest situations to reach are the ones where two sources act on the same register in one cycle. One is a request arriving while the sequencer is in FIRST. The other is a port write aimed at the pointer being advanced. The bench reaches both by driving the request manually and raising the second input exactly one clock after the request is accepted. The scoreboard then flags any extra bus access, and register readback shows which value was kept. Byte mode is checked with memory words whose upper bytes differ from their lower bytes. It is exercised through an advancing pointer, the stack pointer and a fixed register, which give distinct address pairs.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;

    typedef enum logic [1:0] {
        RULE_FIXED,
        RULE_POST_INC,
        RULE_STACK
    } step_rule_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FIRST,
        S_SECOND,
        S_DONE
    } seq_state_t;

    function automatic step_rule_t rule_of(input int idx, input int sp_idx,
                                           input int auto_lo);
        if (idx == sp_idx)
            return RULE_STACK;
        else if (idx >= auto_lo)
            return RULE_POST_INC;
        else
            return RULE_FIXED;
    endfunction

endpackage

// File: rtl/ptr_step.sv
module ptr_step
    import ptr_regfile_pkg::*;
#(
    parameter int         DW   = 16,
    parameter step_rule_t RULE = RULE_FIXED
) (
    input  logic [DW-1:0] cur,
    input  logic          is_write,
    output logic [DW-1:0] nxt
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (RULE)
            RULE_POST_INC: nxt = cur + ONE;
            RULE_STACK:    nxt = is_write ? (cur - ONE) : (cur + ONE);
            default:       nxt = is_write ? cur : cur;
        endcase
    end

endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
    import ptr_regfile_pkg::*;
#(
    parameter int          NREG     = 8,
    parameter int          DW       = 16,
    parameter int          SP_IDX   = 6,
    parameter int          PC_IDX   = 7,
    parameter int          AUTO_LO  = 4,
    parameter logic [15:0] RESET_PC = 16'h1000,
    localparam int         IW       = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic               step_en,
    input  logic [IW-1:0]      step_sel,
    input  logic               step_write,
    output logic [NREG*DW-1:0] regs_flat
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam step_rule_t    RULE_G = rule_of(g, SP_IDX, AUTO_LO);
        localparam logic [DW-1:0] INIT_G = (g == PC_IDX) ? DW'(RESET_PC) : '0;

        logic [DW-1:0] val_q;
        logic [DW-1:0] val_nxt;

        ptr_step #(
            .DW   (DW),
            .RULE (RULE_G)
        ) u_step (
            .cur      (val_q),
            .is_write (step_write),
            .nxt      (val_nxt)
        );

        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= INIT_G;
            else if (wr_en && (wr_sel == IW'(g)))
                val_q <= wr_data;
            else if (step_en && (step_sel == IW'(g)))
                val_q <= val_nxt;
        end

        assign regs_flat[g*DW +: DW] = val_q;
    end

endmodule

// File: rtl/ptr_seq.sv
module ptr_seq
    import ptr_regfile_pkg::*;
#(
    parameter int  NREG = 8,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [IW-1:0] req_reg,
    input  logic          req_write,
    input  logic          dbl_flag,
    output seq_state_t    state,
    output logic [IW-1:0] acc_reg,
    output logic          acc_write,
    output logic          acc_dbl,
    output logic          step_en,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          lo_cap,
    output logic          done
);

    seq_state_t    state_q, state_d;
    logic [IW-1:0] reg_q;
    logic          write_q;
    logic          dbl_q;

    // state register and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            reg_q   <= '0;
            write_q <= 1'b0;
            dbl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                reg_q   <= req_reg;
                write_q <= req_write;
                dbl_q   <= dbl_flag && !req_write;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_FIRST;
            S_FIRST:  state_d = dbl_q ? S_SECOND : S_DONE;
            S_SECOND: state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        step_en = 1'b0;
        lo_cap  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FIRST: begin
                mem_rd  = !write_q;
                mem_wr  = write_q;
                step_en = 1'b1;
            end
            S_SECOND: begin
                mem_rd  = 1'b1;
                step_en = 1'b1;
                lo_cap  = 1'b1;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign state     = state_q;
    assign acc_reg   = reg_q;
    assign acc_write = write_q;
    assign acc_dbl   = dbl_q;

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptr_regfile_pkg::*;
#(
    parameter int          NREG     = 8,
    parameter int          DW       = 16,
    parameter int          BW       = 8,
    parameter int          SP_IDX   = 6,
    parameter int          PC_IDX   = 7,
    parameter int          AUTO_LO  = 4,
    parameter logic [15:0] RESET_PC = 16'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [15:0]   wr_data,
    input  logic [2:0]    rd_sel,
    output logic [15:0]   rd_data,
    input  logic          dbl_arm,
    output logic          dbl_flag,
    input  logic          req_valid,
    input  logic [2:0]    req_reg,
    input  logic          req_write,
    output logic [15:0]   mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [15:0]   mem_rdata,
    output logic          op_done,
    output logic [15:0]   op_data
);

    localparam int IW = $clog2(NREG);

    logic [NREG*DW-1:0] regs_flat;
    logic [DW-1:0]      reg_arr [NREG];

    seq_state_t    state;
    logic [IW-1:0] acc_reg;
    logic          acc_write;
    logic          acc_dbl;
    logic          step_en;
    logic          lo_cap;
    logic          second_phase;

    logic          dbl_q;
    logic [BW-1:0] lo_q;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] assembled;

    ptr_bank #(
        .NREG     (NREG),
        .DW       (DW),
        .SP_IDX   (SP_IDX),
        .PC_IDX   (PC_IDX),
        .AUTO_LO  (AUTO_LO),
        .RESET_PC (RESET_PC)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (IW'(wr_sel)),
        .wr_data    (DW'(wr_data)),
        .step_en    (step_en),
        .step_sel   (acc_reg),
        .step_write (acc_write),
        .regs_flat  (regs_flat)
    );

    ptr_seq #(
        .NREG (NREG)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_reg   (IW'(req_reg)),
        .req_write (req_write),
        .dbl_flag  (dbl_q),
        .state     (state),
        .acc_reg   (acc_reg),
        .acc_write (acc_write),
        .acc_dbl   (acc_dbl),
        .step_en   (step_en),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .lo_cap    (lo_cap),
        .done      (op_done)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign reg_arr[g] = regs_flat[g*DW +: DW];
    end

    assign second_phase = (state == S_SECOND);
    assign rd_data      = 16'(reg_arr[IW'(rd_sel)]);
    assign mem_addr     = 16'(reg_arr[acc_reg]);

    // byte-mode arm: a new arm wins over the clear at completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbl_q <= 1'b0;
        else if (dbl_arm)
            dbl_q <= 1'b1;
        else if (op_done)
            dbl_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (lo_cap)
            lo_q <= mem_rdata[BW-1:0];
    end

    always_comb begin
        if (acc_write)
            assembled = hold_q;
        else if (acc_dbl)
            assembled = {mem_rdata[BW-1:0], lo_q};
        else
            assembled = DW'(mem_rdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (op_done)
            hold_q <= assembled;
    end

    assign dbl_flag = dbl_q;
    assign op_data  = op_done ? 16'(assembled) : 16'(hold_q);

endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk #(
    parameter int DW     = 16,
    parameter int NREG   = 8,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [15:0]        mem_addr,
    input logic               op_done,
    input logic               dbl_arm,
    input logic               dbl_flag,
    input logic               wr_en,
    input logic [2:0]         wr_sel,
    input logic [NREG*DW-1:0] regs_flat,
    input logic [2:0]         acc_reg,
    input logic               second_phase
);

    logic [DW-1:0] sp_v, pc_v;
    logic [4*DW-1:0] low_v;
    assign sp_v  = regs_flat[SP_IDX*DW +: DW];
    assign pc_v  = regs_flat[PC_IDX*DW +: DW];
    assign low_v = regs_flat[4*DW-1:0];

    p_excl_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !dbl_arm) |=> !dbl_flag);

    p_low_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(low_v));

    p_stack_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && acc_reg == 3'(SP_IDX) && !(wr_en && wr_sel == 3'(SP_IDX)))
        |=> (sp_v == $past(sp_v) - 1'b1));

    p_pc_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && acc_reg == 3'(PC_IDX) && !(wr_en && wr_sel == 3'(PC_IDX)))
        |=> (pc_v == $past(pc_v) + 1'b1));

    p_second_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (second_phase && acc_reg >= 3'd4 && !$past(wr_en))
        |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind ptr_regfile ptr_regfile_chk #(
    .DW     (DW),
    .NREG   (NREG),
    .SP_IDX (SP_IDX),
    .PC_IDX (PC_IDX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_addr     (mem_addr),
    .op_done      (op_done),
    .dbl_arm      (dbl_arm),
    .dbl_flag     (dbl_flag),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .regs_flat    (regs_flat),
    .acc_reg      (3'(acc_reg)),
    .second_phase (second_phase)
);

// File: tb/ptr_regfile_bench.sv
module ptr_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        dbl_arm = 1'b0;
    logic        dbl_flag;
    logic        req_valid = 1'b0;
    logic [2:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_rdata = '0;
    logic        op_done;
    logic [15:0] op_data;

    always #10 clk = ~clk;

    ptr_regfile u_ptr_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .dbl_arm(dbl_arm), .dbl_flag(dbl_flag), .req_valid(req_valid),
        .req_reg(req_reg), .req_write(req_write), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
        .op_done(op_done), .op_data(op_data)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h5E};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

    typedef struct {
        bit          is_done;
        bit          wr;
        logic [15:0] val;
        string       tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] m_reg [8];
    logic [15:0] last_op = '0;
    bit          m_dbl = 0;

    function automatic logic [15:0] model_step(input int idx, input bit wr,
                                               input logic [15:0] v);
        if (idx == 6) return wr ? v - 16'd1 : v + 16'd1;
        if (idx >= 4) return v + 16'd1;
        return v;
    endfunction

    // monitor: compares every bus access and completion with the queue
    always @(negedge clk) begin
        if (rst_n && (mem_rd || mem_wr)) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected access addr=%h expected none", mem_addr);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.is_done || it.wr != mem_wr || it.val != mem_addr) begin
                    n_bad++;
                    $display("FAIL %s access wr=%0b addr=%h expected done=%0b wr=%0b addr=%h",
                             it.tag, mem_wr, mem_addr, it.is_done, it.wr, it.val);
                end
            end
        end
        if (rst_n && op_done) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected done data=%h expected none", op_data);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (!it.is_done || it.val != op_data) begin
                    n_bad++;
                    $display("FAIL %s done data=%h expected done=%0b data=%h",
                             it.tag, op_data, it.is_done, it.val);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_access(input int idx, input bit wr, input string tag);
        logic [15:0] a1, a2, op;
        bit dbl_eff;
        dbl_eff = m_dbl && !wr;
        a1 = m_reg[idx];
        sb_q.push_back('{0, wr, a1, tag});
        m_reg[idx] = model_step(idx, wr, m_reg[idx]);
        if (dbl_eff) begin
            a2 = m_reg[idx];
            sb_q.push_back('{0, 0, a2, tag});
            m_reg[idx] = model_step(idx, 0, m_reg[idx]);
            op = {mem_word(a2)[7:0], mem_word(a1)[7:0]};
        end else if (!wr) op = mem_word(a1);
        else op = last_op;
        sb_q.push_back('{1, 0, op, tag});
        last_op = op;
        m_dbl = 0;
    endtask

    task automatic drive_req(input int idx, input bit wr);
        @(posedge clk); #1;
        req_valid = 1'b1; req_reg = 3'(idx); req_write = wr;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!op_done);
    endtask

    task automatic do_access(input int idx, input bit wr, input string tag);
        push_access(idx, wr, tag);
        drive_req(idx, wr);
        wait_done();
    endtask

    task automatic reg_write(input int idx, input logic [15:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = 3'(idx); wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_reg[idx] = v;
    endtask

    task automatic chk_reg(input int idx, input string tag);
        @(posedge clk); #1;
        rd_sel = 3'(idx);
        @(negedge clk);
        check(tag, rd_data, m_reg[idx]);
    endtask

    task automatic arm();
        @(posedge clk); #1;
        dbl_arm = 1'b1;
        @(posedge clk); #1;
        dbl_arm = 1'b0;
        m_dbl = 1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = (i == 7) ? 16'h1000 : 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 op_done", {15'd0, op_done}, 16'd0);
        check("R1 dbl_flag", {15'd0, dbl_flag}, 16'd0);
        for (int i = 0; i < 8; i++) chk_reg(i, "R1 reset value");

        // R2 register port
        for (int i = 0; i < 7; i++) reg_write(i, 16'h0100 * (i + 1) + 16'h0011);
        for (int i = 0; i < 7; i++) chk_reg(i, "R2 port readback");

        // R3 R4 R7 single accesses
        do_access(4, 0, "R7 read via r4");
        chk_reg(4, "R4 r4 after read");
        do_access(7, 0, "R4 immediate via r7");
        chk_reg(7, "R4 r7 after read");
        do_access(5, 1, "R3 write via r5");
        chk_reg(5, "R4 r5 after write");
        // R5 stack pointer both directions
        do_access(6, 0, "R5 stack read");
        chk_reg(6, "R5 sp after read");
        do_access(6, 1, "R5 stack write");
        chk_reg(6, "R5 sp after write");
        // R6 fixed registers
        do_access(1, 0, "R6 read via r1");
        chk_reg(1, "R6 r1 unchanged");
        do_access(2, 1, "R6 write via r2");
        chk_reg(2, "R6 r2 unchanged");
        // wrap cases
        reg_write(4, 16'hFFFF);
        do_access(4, 0, "R4 wrap read");
        chk_reg(4, "R4 wrap to zero");
        reg_write(6, 16'h0000);
        do_access(6, 1, "R5 wrap write");
        chk_reg(6, "R5 wrap to ffff");

        // R8 byte mode through r5
        reg_write(5, 16'h20FE);
        arm();
        @(negedge clk);
        check("R8 flag set", {15'd0, dbl_flag}, 16'd1);
        do_access(5, 0, "R8 byte read r5");
        @(negedge clk);
        check("R9 flag cleared", {15'd0, dbl_flag}, 16'd0);
        chk_reg(5, "R8 r5 advanced by two");
        do_access(5, 0, "R9 next read single");
        // byte mode through stack and fixed register
        arm();
        do_access(6, 0, "R8 byte read sp");
        chk_reg(6, "R8 sp advanced by two");
        reg_write(0, 16'h7A31);
        arm();
        do_access(0, 0, "R6 byte read r0 same addr");
        chk_reg(0, "R6 r0 unchanged");
        // R9 write with flag armed
        arm();
        do_access(4, 1, "R9 write ignores byte mode");
        @(negedge clk);
        check("R9 flag cleared after write", {15'd0, dbl_flag}, 16'd0);
        chk_reg(4, "R9 r4 single step");

        // R11 operand hold
        do_access(7, 0, "R11 read");
        repeat (2) @(negedge clk);
        check("R11 op_data held", op_data, last_op);
        do_access(5, 1, "R11 write completion");
        @(negedge clk);
        check("R11 op_data kept after write", op_data, last_op);

        // R10 request while busy
        push_access(4, 0, "R10 busy base");
        @(posedge clk); #1;
        req_valid = 1'b1; req_reg = 3'd4; req_write = 1'b0;
        @(posedge clk); #1;
        req_reg = 3'd5;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
        chk_reg(5, "R10 r5 untouched");
        check("R10 queue empty", 16'(sb_q.size()), 16'd0);

        // R12 port write beats pointer update
        push_access(4, 0, "R12 access");
        @(posedge clk); #1;
        req_valid = 1'b1; req_reg = 3'd4; req_write = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h2222;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_reg[4] = 16'h2222;
        wait_done();
        chk_reg(4, "R12 port value kept");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", 16'(sb_q.size()), 16'd0);
        finish_run();
    end

endmodule